// File: doc/BRIEF.md
# Expansion-Bus Address Decoder with Control and Input Registers

This block sits on the external bus of an 8-bit microcontroller whose address bus is 16 bits wide. It turns each bus access into active-low selects for an external 8 KB RAM, an external 16 KB EPROM and an LCD data latch. It also holds two small registers of its own. One is an 8-bit control register that software can write but not read back. The other is a read-only port that shows eight external input lines as they are at that moment.

Only the top 4 and the bottom 6 address bits reach the block, so decoding is partial. Every select is qualified by the bus phase signal `bus_e`. A register write takes effect when `bus_e` falls, using the data and address that were present while it was high. Every output is registered, so each output follows its inputs one clock later.

Bit 0 of the control register drives the enable for the pull-up and pull-down resistor networks. On the input port, bit 0 is the start button and bits 1 to 4 are the configuration switches.

Top module: `memdec_top`

## Requirements
- R1: One clock after a cycle in which `bus_e`=1 and `addr_hi` is 4'h6 or 4'h7 (the window $6000-$7FFF), `ram_cs_n` is 0. Otherwise it is 1.
- R2: One clock after a cycle in which `bus_e`=1 and `addr_hi` is 4'hC to 4'hF (the window $C000-$FFFF), `rom_cs_n` is 0. Otherwise it is 1.
- R3: One clock after a cycle in which `bus_e`=1, `addr_hi`=4'h8 and `addr_lo`=6'h00, `lcd_cs_n` is 0, for both reads and writes.
- R4: A write cycle (`bus_rw`=0) with `addr_hi`=4'h8 and `addr_lo`=6'h01 loads `ctrl_q` with the `wdata` seen while `bus_e` was high. The load happens at the first clock that samples `bus_e` low after that cycle.
- R5: After reset, `ctrl_q` is 8'h00 and `pull_en` is 0.
- R6: `pull_en` always equals bit 0 of the control register.
- R7: A read of $8001 leaves `rdata_oe` at 0 and does not change `ctrl_q`.
- R8: One clock after a read cycle (`bus_e`=1, `bus_rw`=1) of $8002, `rdata_oe` is 1 and `rdata` equals the `gpi` value sampled in that cycle. Bit 0 is the start button and bits 1 to 4 are the switches. In every other case `rdata_oe` is 0 and `rdata` is 8'h00.
- R9: While `bus_e` is 0, no select, output enable, write enable or `rdata_oe` is asserted, and no register is written.
- R10: In the $8xxx region only `addr_lo` is compared, so $8041, $80C1 and $8FC1 all reach the control register, and $8042 and $8FC2 both reach the input port.
- R11: `mem_oe_n` is 0 one clock after a read cycle of RAM or EPROM. `mem_we_n` is 0 one clock after a write cycle of RAM, and is never asserted for EPROM.
- R12: Writes to $8002, to $8000, or to unused $8xxx offsets leave `ctrl_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_e | input | 1 | Bus phase enable; accesses are valid while high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 4 | Address bits 15..12 |
| addr_lo | input | 6 | Address bits 5..0 |
| wdata | input | 8 | Write data from the bus |
| gpi | input | 8 | External inputs (bit 0 start button, bits 1-4 switches) |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | EPROM chip select, active low |
| lcd_cs_n | output | 1 | LCD data latch select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| ctrl_q | output | 8 | Control register contents |
| pull_en | output | 1 | Enable for the pull-up and pull-down resistor networks |
| rdata | output | 8 | Read data for the bus |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
The bench goes after aliasing in the $8xxx region. A decoder that compared more address bits would miss writes to $80C1 and $8FC1, and reads of $8FC2 would return nothing. It checks that a read of the write-only register leaves `rdata_oe` low, which a design that mirrored the register onto the bus would break. It changes `wdata` once `bus_e` has fallen, so a design that loaded the data present at the falling edge would store the wrong byte. It also sends accesses with `bus_e` low and writes to the neighbouring offsets. These would expose a select or register that was not qualified by the phase signal, and an offset compare that matched too loosely.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  typedef struct packed {
    logic ram;
    logic rom;
    logic lcd;
    logic ctrl;
    logic gpi;
  } memdec_hit_t;
endpackage

// File: rtl/memdec_addr_decode.sv
module memdec_addr_decode
  import memdec_pkg::*;
#(
  parameter int HI_W        = 4,
  parameter int LO_W        = 6,
  parameter logic [HI_W-1:0] RAM_MASK  = 4'hE,
  parameter logic [HI_W-1:0] RAM_MATCH = 4'h6,
  parameter logic [HI_W-1:0] ROM_MASK  = 4'hC,
  parameter logic [HI_W-1:0] ROM_MATCH = 4'hC,
  parameter logic [HI_W-1:0] REG_HI    = 4'h8,
  parameter logic [LO_W-1:0] LCD_LO    = 6'h00,
  parameter logic [LO_W-1:0] CTRL_LO   = 6'h01,
  parameter logic [LO_W-1:0] GPI_LO    = 6'h02
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [LO_W-1:0] addr_lo,
  output memdec_hit_t     hit
);
  logic in_reg;

  always_comb begin
    in_reg   = (addr_hi == REG_HI);
    hit.ram  = ((addr_hi & RAM_MASK) == RAM_MATCH);
    hit.rom  = ((addr_hi & ROM_MASK) == ROM_MATCH);
    hit.lcd  = in_reg && (addr_lo == LCD_LO);
    hit.ctrl = in_reg && (addr_lo == CTRL_LO);
    hit.gpi  = in_reg && (addr_lo == GPI_LO);
  end
endmodule

// File: rtl/memdec_ctrl_reg.sv
module memdec_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_e,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic              e_q;
  logic              wr_q;
  logic [DATA_W-1:0] data_q;
  logic              e_fall;

  assign e_fall = e_q && !bus_e;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q    <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= '0;
      q      <= RST_VAL;
    end else begin
      e_q <= bus_e;
      if (bus_e) begin
        wr_q   <= wr_hit;
        data_q <= wdata;
      end
      if (e_fall && wr_q) q <= data_q;
    end
  end
endmodule

// File: rtl/memdec_gpi_port.sv
module memdec_gpi_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] gpi,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd_hit;
      rdata    <= rd_hit ? gpi : '0;
    end
  end
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int HI_W     = 4,
  parameter int LO_W     = 6,
  parameter int DATA_W   = 8,
  parameter int PULL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_e,
  input  logic              bus_rw,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [LO_W-1:0]   addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] gpi,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              lcd_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pull_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  memdec_hit_t hit;
  logic        rd_cyc;
  logic        wr_cyc;

  memdec_addr_decode #(.HI_W(HI_W), .LO_W(LO_W)) dec_i (
    .addr_hi (addr_hi),
    .addr_lo (addr_lo),
    .hit     (hit)
  );

  assign rd_cyc = bus_e && bus_rw;
  assign wr_cyc = bus_e && !bus_rw;

  memdec_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .bus_e  (bus_e),
    .wr_hit (wr_cyc && hit.ctrl),
    .wdata  (wdata),
    .q      (ctrl_q)
  );

  memdec_gpi_port #(.DATA_W(DATA_W)) gpi_i (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (rd_cyc && hit.gpi),
    .gpi      (gpi),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  assign pull_en = ctrl_q[PULL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs_n <= 1'b1;
      rom_cs_n <= 1'b1;
      lcd_cs_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
    end else begin
      ram_cs_n <= !(bus_e && hit.ram);
      rom_cs_n <= !(bus_e && hit.rom);
      lcd_cs_n <= !(bus_e && hit.lcd);
      mem_oe_n <= !(rd_cyc && (hit.ram || hit.rom));
      mem_we_n <= !(wr_cyc && hit.ram);
    end
  end
endmodule

// File: rtl/memdec_chk.sv
module memdec_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_e,
  input logic       bus_rw,
  input logic [3:0] addr_hi,
  input logic [5:0] addr_lo,
  input logic [7:0] gpi,
  input logic       ram_cs_n,
  input logic       rom_cs_n,
  input logic       lcd_cs_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic [7:0] ctrl_q,
  input logic [7:0] rdata,
  input logic       rdata_oe
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_e)) |->
      (ram_cs_n && rom_cs_n && lcd_cs_n && mem_oe_n && mem_we_n && !rdata_oe));

  // R1
  ram_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_e) && ($past(addr_hi[3:1]) == 3'b011)) |-> !ram_cs_n);

  // R2
  rom_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_e) && ($past(addr_hi[3:2]) == 2'b11)) |-> !rom_cs_n);

  // R7
  wo_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rw) && ($past(addr_hi) == 4'h8) && ($past(addr_lo) == 6'h01))
      |-> !rdata_oe);

  // R8
  gpi_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_e) && $past(bus_rw) && ($past(addr_hi) == 4'h8)
      && ($past(addr_lo) == 6'h02)) |-> (rdata_oe && (rdata == $past(gpi))));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !($past(bus_e, 2) && !$past(bus_e))) |-> $stable(ctrl_q));

  // R11
  rom_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> mem_we_n);
endmodule

bind memdec_top memdec_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_e    (bus_e),
  .bus_rw   (bus_rw),
  .addr_hi  (addr_hi),
  .addr_lo  (addr_lo),
  .gpi      (gpi),
  .ram_cs_n (ram_cs_n),
  .rom_cs_n (rom_cs_n),
  .lcd_cs_n (lcd_cs_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .ctrl_q   (ctrl_q),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/memdec_tb.sv
module memdec_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_e = 1'b0;
  logic       bus_rw = 1'b1;
  logic [3:0] addr_hi = '0;
  logic [5:0] addr_lo = '0;
  logic [7:0] wdata = '0;
  logic [7:0] gpi = '0;
  logic       ram_cs_n, rom_cs_n, lcd_cs_n, mem_oe_n, mem_we_n, pull_en, rdata_oe;
  logic [7:0] ctrl_q, rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memdec_top dut_i (
    .clk(clk), .rst(rst), .bus_e(bus_e), .bus_rw(bus_rw),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .wdata(wdata), .gpi(gpi),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .lcd_cs_n(lcd_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .ctrl_q(ctrl_q),
    .pull_en(pull_en), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one E-high cycle, then E low; sample the registered outputs of the access
  task automatic access(input logic rw, input logic [3:0] hi, input logic [5:0] lo,
                        input logic [7:0] d);
    @(negedge clk);
    bus_e = 1'b1; bus_rw = rw; addr_hi = hi; addr_lo = lo; wdata = d;
    @(negedge clk);
  endtask

  task automatic end_access();
    bus_e = 1'b0; bus_rw = 1'b1; wdata = 8'h5A;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5 ctrl_q", ctrl_q, 8'h00);
    check("R5 pull_en", pull_en, 1'b0);
    check("R9 idle selects", {ram_cs_n, rom_cs_n, lcd_cs_n, mem_oe_n, mem_we_n, rdata_oe},
          6'b111110);
  endtask

  task automatic t_ram();
    access(1'b1, 4'h6, 6'h3F, 8'h00);
    check("R1 ram $6xxx", ram_cs_n, 1'b0);
    check("R11 ram read oe", {mem_oe_n, mem_we_n}, 2'b01);
    end_access();
    access(1'b0, 4'h7, 6'h00, 8'h11);
    check("R1 ram $7xxx", {ram_cs_n, rom_cs_n}, 2'b01);
    check("R11 ram write we", {mem_oe_n, mem_we_n}, 2'b10);
    end_access();
    access(1'b1, 4'h5, 6'h00, 8'h00);
    check("R1 ram not at $5xxx", {ram_cs_n, rom_cs_n, mem_oe_n}, 3'b111);
    end_access();
  endtask

  task automatic t_rom();
    for (int h = 12; h < 16; h++) begin
      access(1'b1, 4'(h), 6'h15, 8'h00);
      check("R2 rom window", {rom_cs_n, ram_cs_n, mem_oe_n}, 3'b010);
      end_access();
    end
    access(1'b0, 4'hD, 6'h00, 8'h22);
    check("R11 rom write has no we", {rom_cs_n, mem_we_n}, 2'b01);
    end_access();
    access(1'b1, 4'hB, 6'h00, 8'h00);
    check("R2 rom not at $Bxxx", rom_cs_n, 1'b1);
    end_access();
  endtask

  task automatic t_lcd();
    access(1'b0, 4'h8, 6'h00, 8'h41);
    check("R3 lcd write", lcd_cs_n, 1'b0);
    end_access();
    access(1'b1, 4'h8, 6'h00, 8'h00);
    check("R3 lcd read", {lcd_cs_n, rdata_oe}, 2'b00);
    end_access();
    access(1'b1, 4'h9, 6'h00, 8'h00);
    check("R3 lcd needs $8 top", lcd_cs_n, 1'b1);
    end_access();
  endtask

  task automatic t_ctrl_write();
    access(1'b0, 4'h8, 6'h01, 8'hA7);
    check("R4 no load while E high", ctrl_q, 8'h00);
    end_access();
    check("R4 ctrl load", ctrl_q, 8'hA7);
    check("R6 pull_en follows bit0", pull_en, 1'b1);
    access(1'b0, 4'h8, 6'h01, 8'h3E);
    end_access();
    check("R6 pull_en cleared", {ctrl_q, pull_en}, {8'h3E, 1'b0});
  endtask

  task automatic t_ctrl_read();
    access(1'b1, 4'h8, 6'h01, 8'hFF);
    check("R7 no drive on read", rdata_oe, 1'b0);
    end_access();
    check("R7 ctrl unchanged by read", ctrl_q, 8'h3E);
  endtask

  task automatic t_gpi();
    gpi = 8'b0001_0101;
    access(1'b1, 4'h8, 6'h02, 8'h00);
    check("R8 gpi read oe", rdata_oe, 1'b1);
    check("R8 gpi data", rdata, 8'h15);
    end_access();
    check("R8 oe drops after", {rdata_oe, rdata}, 9'h000);
    gpi = 8'hEA;
    access(1'b1, 4'h8, 6'h02, 8'h00);
    check("R8 gpi live value", rdata, 8'hEA);
    end_access();
  endtask

  task automatic t_e_low();
    @(negedge clk);
    bus_e = 1'b0; bus_rw = 1'b0; addr_hi = 4'h8; addr_lo = 6'h01; wdata = 8'hC3;
    @(negedge clk);
    check("R9 no selects without E", {ram_cs_n, rom_cs_n, lcd_cs_n, mem_we_n}, 4'hF);
    addr_hi = 4'h6;
    @(negedge clk);
    check("R9 ram not selected without E", ram_cs_n, 1'b1);
    @(negedge clk);
    check("R9 no ctrl write without E", ctrl_q, 8'h3E);
    bus_rw = 1'b1; addr_hi = 4'h8; addr_lo = 6'h02;
    @(negedge clk);
    check("R9 no read drive without E", rdata_oe, 1'b0);
  endtask

  task automatic t_alias();
    access(1'b0, 4'h8, 6'h01, 8'h81);
    end_access();
    check("R10 alias $8041", ctrl_q, 8'h81);
    access(1'b0, 4'h8, 6'h01, 8'h92);
    end_access();
    check("R10 alias $80C1", ctrl_q, 8'h92);
    access(1'b0, 4'h8, 6'h01, 8'h03);
    end_access();
    check("R10 alias $8FC1", ctrl_q, 8'h03);
    gpi = 8'h1E;
    access(1'b1, 4'h8, 6'h02, 8'h00);
    check("R10 alias $8FC2 read", {rdata_oe, rdata}, {1'b1, 8'h1E});
    end_access();
  endtask

  task automatic t_other_writes();
    access(1'b0, 4'h8, 6'h02, 8'hEE);
    end_access();
    check("R12 write $8002 ignored", ctrl_q, 8'h03);
    access(1'b0, 4'h8, 6'h00, 8'hEE);
    end_access();
    check("R12 write $8000 ignored", ctrl_q, 8'h03);
    access(1'b0, 4'h8, 6'h03, 8'hEE);
    end_access();
    check("R12 write $8003 ignored", ctrl_q, 8'h03);
    access(1'b0, 4'h9, 6'h01, 8'hEE);
    end_access();
    check("R12 write $9001 ignored", ctrl_q, 8'h03);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5 reset clears ctrl", {ctrl_q, pull_en}, 9'h000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram();
    t_rom();
    t_lcd();
    t_ctrl_write();
    t_ctrl_read();
    t_gpi();
    t_e_low();
    t_alias();
    t_other_writes();
    t_reset_again();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule